// File: doc/BRIEF.md
# Interrupt Cause Expander and Priority Resolver

This block sits between the coarse interrupt status of a processor interface and the dispatch logic of the processor. It receives a 14-bit coarse cause word, the hardware mask for that word, and the status words of several devices. These are a memory-protection status, a DSP/ARAM control word, an audio control word and three serial-expansion channel status words. From them it builds a 32-bit fine cause vector. Each fine bit names one interrupt source.

Two software mask words clear fine bits before any priority is applied. The remaining bits pass through an ordered table of group masks. A group may hold bits scattered over the whole vector. The first group that intersects the fine cause wins. Inside that group, the most significant set bit is chosen, and its leading-zero count becomes the 5-bit interrupt number.

A one-cycle request strobe starts a resolution. One cycle later the block reports a valid pulse and the number. For numbers at or above a threshold, it also raises a record strobe and latches the number together with the timestamp sampled at the request.

Top module: `intr_resolver`

## Requirements
- R1: While reset is asserted and directly after it, `irq_valid` and `rec_stb` are 0, and `irq_num`, `rec_num` and `rec_time` are 0.
- R2: Coarse bit positions are ERROR 0, RSW 1, DI 2, SI 3, EXI 4, AI 5, DSP 6, MEM 7, VI 8, PE_TOKEN 9, PE_FINISH 10, CP 11, DEBUG 12, HSP 13, and the switch-state bit is 16. Bit 16 is ignored. No interrupt is reported when coarse bits 13..0 are all zero, or when they share no set bit with `hw_mask`. The hardware mask only gates reporting: it does not remove fine bits.
- R3: With coarse MEM set, memory status bits 0x01, 0x02, 0x04, 0x08 and 0x10 raise fine bits 31, 30, 29, 28 and 27. These fine bits give interrupt numbers 0 to 4.
- R4: With coarse DSP set, DSP status bit 0x08 raises fine bit 26, bit 0x20 raises fine bit 25 and bit 0x80 raises fine bit 24. With coarse AI set, audio bit 0x08 raises fine bit 23. Status bits are ignored while their coarse bit is clear.
- R5: With coarse EXI set, in channel c (0..2), status 0x02 raises fine bit 22-3c and 0x08 raises fine bit 21-3c. Status 0x800 raises fine bit 20-3c for channels 0 and 1 only.
- R6: The other coarse bits map one-to-one to fine bits: CP 14, PE_TOKEN 13, PE_FINISH 12, SI 11, DI 10, RSW 9, ERROR 8, VI 7, DEBUG 6, HSP 5.
- R7: A fine bit that is set in `sw_mask_prev` or in `sw_mask_cur` is cleared before priority. No interrupt is reported when nothing remains.
- R8: Group order, from highest to lowest: ERROR; DEBUG; fine bits 31..27; RSW; VI; PE_TOKEN+PE_FINISH; HSP; {fine 25, 24, 23, 22..15, SI, DI}; fine 26; CP; then all bits. The first group with a set fine bit wins.
- R9: The reported number is the count of leading zeros of the winning group ANDed with the fine cause, that is 31 minus its highest set bit.
- R10: When the reported number is 5 or more, `rec_stb` pulses with `irq_valid`, `rec_num` takes the number and `rec_time` takes the timestamp of the request cycle. Otherwise `rec_num` and `rec_time` hold their values.
- R11: `irq_valid` is a one-cycle pulse in the cycle after `req`. Without `req`, no pulse occurs, whatever the causes are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Resolution request strobe |
| coarse_cause | input | 17 | Coarse cause word (bit 16 is the switch state) |
| hw_mask | input | 14 | Hardware mask over coarse bits 13..0 |
| mem_stat | input | 16 | Memory protection status |
| dsp_stat | input | 16 | DSP/ARAM control status |
| ai_ctrl | input | 32 | Audio control word |
| exi_stat | input | 3x32 | Status word of each expansion channel |
| sw_mask_prev | input | 32 | Previous software mask |
| sw_mask_cur | input | 32 | Current software mask |
| timestamp | input | TS_W | Free-running time value |
| irq_valid | output | 1 | Interrupt number is valid (pulse) |
| irq_num | output | 5 | Chosen interrupt number |
| rec_stb | output | 1 | Record strobe for numbers at or above 5 |
| rec_num | output | 5 | Last recorded number |
| rec_time | output | TS_W | Timestamp of the last recorded number |

## Verification
The bench sets a coarse bit that is enabled in the hardware mask next to one that is masked out, and the masked-out bit has higher priority. A design that applied the hardware mask to the fine vector would report the wrong winner. The bench also pairs a DSP_AI cause with a CP cause, and a DSP_DSP cause with a DSP_AI cause. A design that ranked plain bit order instead of the group table would pick fine bit 26 over 24, or CP over DSP_AI. Multi-bit groups (all memory bits, PE token with finish, the mixed device group) check that the highest set bit wins, not the lowest. Edge mappings are also covered: the missing channel-2 EXT bit, status bits with their coarse bit clear, and the switch-state bit alone. Each of these would raise a false interrupt if decoded wrongly. The threshold numbers 4 and 5 show whether the record strobe and the held record values are correct.

// File: rtl/intr_pkg.sv
package intr_pkg;

  localparam int COARSE_W = 14;
  localparam int FINE_W   = 32;
  localparam int NUM_W    = $clog2(FINE_W);
  localparam int EXI_CH   = 3;
  localparam int NGRP     = 11;
  localparam int REC_MIN  = 5;

  // coarse cause positions
  localparam int C_ERR  = 0;
  localparam int C_RSW  = 1;
  localparam int C_DI   = 2;
  localparam int C_SI   = 3;
  localparam int C_EXI  = 4;
  localparam int C_AI   = 5;
  localparam int C_DSP  = 6;
  localparam int C_MEM  = 7;
  localparam int C_VI   = 8;
  localparam int C_PET  = 9;
  localparam int C_PEF  = 10;
  localparam int C_CP   = 11;
  localparam int C_DBG  = 12;
  localparam int C_HSP  = 13;

  // fine cause positions
  localparam int F_MEM0  = 31;
  localparam int F_MADDR = 27;
  localparam int F_DAI   = 26;
  localparam int F_DARAM = 25;
  localparam int F_DDSP  = 24;
  localparam int F_AI    = 23;
  localparam int F_EXI0  = 22;
  localparam int F_CP    = 14;
  localparam int F_PET   = 13;
  localparam int F_PEF   = 12;
  localparam int F_SI    = 11;
  localparam int F_DI    = 10;
  localparam int F_RSW   = 9;
  localparam int F_ERR   = 8;
  localparam int F_VI    = 7;
  localparam int F_DBG   = 6;
  localparam int F_HSP   = 5;

  typedef logic [FINE_W-1:0] fine_t;
  typedef logic [NUM_W-1:0]  num_t;

  // ordered priority groups, index 0 is highest
  function automatic fine_t grp_mask(input int g);
    fine_t m;
    m = '0;
    case (g)
      0: m[F_ERR] = 1'b1;
      1: m[F_DBG] = 1'b1;
      2: m[F_MEM0:F_MADDR] = '1;
      3: m[F_RSW] = 1'b1;
      4: m[F_VI] = 1'b1;
      5: begin m[F_PET] = 1'b1; m[F_PEF] = 1'b1; end
      6: m[F_HSP] = 1'b1;
      7: begin
        m[F_DARAM:F_EXI0 - 3*EXI_CH + 2] = '1;
        m[F_SI] = 1'b1;
        m[F_DI] = 1'b1;
      end
      8: m[F_DAI] = 1'b1;
      9: m[F_CP] = 1'b1;
      default: m = '1;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/intr_expand.sv
module intr_expand
  import intr_pkg::*;
(
  input  logic [COARSE_W-1:0]          coarse,
  input  logic [15:0]                  mem_stat,
  input  logic [15:0]                  dsp_stat,
  input  logic [31:0]                  ai_ctrl,
  input  logic [EXI_CH-1:0][31:0]      exi_stat,
  output fine_t                        fine
);

  fine_t exi_part [EXI_CH];
  fine_t base;

  // one-to-one and device sub-status mapping
  always_comb begin
    base = '0;
    if (coarse[C_MEM]) begin
      for (int i = 0; i < 5; i++) base[F_MEM0 - i] = mem_stat[i];
    end
    if (coarse[C_DSP]) begin
      base[F_DAI]   = dsp_stat[3];
      base[F_DARAM] = dsp_stat[5];
      base[F_DDSP]  = dsp_stat[7];
    end
    if (coarse[C_AI]) base[F_AI] = ai_ctrl[3];
    base[F_CP]  = coarse[C_CP];
    base[F_PET] = coarse[C_PET];
    base[F_PEF] = coarse[C_PEF];
    base[F_SI]  = coarse[C_SI];
    base[F_DI]  = coarse[C_DI];
    base[F_RSW] = coarse[C_RSW];
    base[F_ERR] = coarse[C_ERR];
    base[F_VI]  = coarse[C_VI];
    base[F_DBG] = coarse[C_DBG];
    base[F_HSP] = coarse[C_HSP];
  end

  // expansion channels; the last channel carries no attach/detach bit
  for (genvar c = 0; c < EXI_CH; c++) begin : g_ch
    always_comb begin
      exi_part[c] = '0;
      if (coarse[C_EXI]) begin
        exi_part[c][F_EXI0 - 3*c]     = exi_stat[c][1];
        exi_part[c][F_EXI0 - 3*c - 1] = exi_stat[c][3];
        if (c < EXI_CH - 1)
          exi_part[c][F_EXI0 - 3*c - 2] = exi_stat[c][11];
      end
    end
  end

  always_comb begin
    fine = base;
    for (int c = 0; c < EXI_CH; c++) fine = fine | exi_part[c];
  end

  logic unused_stat;
  always_comb begin
    unused_stat = ^{mem_stat[15:5], dsp_stat[15:8], dsp_stat[6], dsp_stat[4],
                    dsp_stat[2:0], ai_ctrl[31:4], ai_ctrl[2:0]};
    for (int c = 0; c < EXI_CH; c++)
      unused_stat = unused_stat ^ (^exi_stat[c]);
  end

endmodule

// File: rtl/intr_clz.sv
module intr_clz #(
  parameter int W  = 32,
  localparam int CW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);

  // highest set bit wins; zero input yields W-1 (never used)
  always_comb begin
    cnt = CW'(W - 1);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) cnt = CW'(W - 1 - i);
    end
  end

endmodule

// File: rtl/intr_prio.sv
module intr_prio
  import intr_pkg::*;
(
  input  fine_t cause,
  output logic  any,
  output num_t  num
);

  logic [NGRP-1:0] hit;
  fine_t           chosen;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign hit[g] = |(cause & grp_mask(g));
  end

  // scan from lowest to highest so the highest priority hit overrides
  always_comb begin
    chosen = '0;
    for (int g = NGRP - 1; g >= 0; g--) begin
      if (hit[g]) chosen = cause & grp_mask(g);
    end
  end

  assign any = |hit;

  intr_clz #(.W(FINE_W)) u_clz (
    .vec (chosen),
    .cnt (num)
  );

endmodule

// File: rtl/intr_resolver.sv
module intr_resolver
  import intr_pkg::*;
#(
  parameter int TS_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req,
  input  logic [16:0]              coarse_cause,
  input  logic [COARSE_W-1:0]      hw_mask,
  input  logic [15:0]              mem_stat,
  input  logic [15:0]              dsp_stat,
  input  logic [31:0]              ai_ctrl,
  input  logic [EXI_CH-1:0][31:0]  exi_stat,
  input  logic [FINE_W-1:0]        sw_mask_prev,
  input  logic [FINE_W-1:0]        sw_mask_cur,
  input  logic [TS_W-1:0]          timestamp,
  output logic                     irq_valid,
  output logic [NUM_W-1:0]         irq_num,
  output logic                     rec_stb,
  output logic [NUM_W-1:0]         rec_num,
  output logic [TS_W-1:0]          rec_time
);

  logic [COARSE_W-1:0] coarse;
  fine_t               fine;
  fine_t               fine_open;
  logic                gate;
  logic                any;
  num_t                num;

  logic                valid_d, rec_d;
  logic                num_en, rec_en;

  logic unused_state;
  assign unused_state = ^coarse_cause[16:COARSE_W];

  assign coarse = coarse_cause[COARSE_W-1:0];

  intr_expand u_expand (
    .coarse   (coarse),
    .mem_stat (mem_stat),
    .dsp_stat (dsp_stat),
    .ai_ctrl  (ai_ctrl),
    .exi_stat (exi_stat),
    .fine     (fine)
  );

  assign fine_open = fine & ~(sw_mask_prev | sw_mask_cur);

  intr_prio u_prio (
    .cause (fine_open),
    .any   (any),
    .num   (num)
  );

  // next state
  always_comb begin
    gate    = (|coarse) && (|(coarse & hw_mask));
    valid_d = req && gate && any;
    rec_d   = valid_d && (int'(num) >= REC_MIN);
    num_en  = valid_d;
    rec_en  = rec_d;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_valid <= 1'b0;
      rec_stb   <= 1'b0;
      irq_num   <= '0;
      rec_num   <= '0;
      rec_time  <= '0;
    end else begin
      irq_valid <= valid_d;
      rec_stb   <= rec_d;
      if (num_en) irq_num <= num;
      if (rec_en) begin
        rec_num  <= num;
        rec_time <= timestamp;
      end
    end
  end

endmodule

// File: rtl/intr_resolver_chk.sv
module intr_resolver_chk
  import intr_pkg::*;
#(
  parameter int TS_W = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req,
  input logic [16:0]             coarse_cause,
  input logic [FINE_W-1:0]       sw_mask_prev,
  input logic [FINE_W-1:0]       sw_mask_cur,
  input logic [TS_W-1:0]         timestamp,
  input logic                    irq_valid,
  input logic [NUM_W-1:0]        irq_num,
  input logic                    rec_stb,
  input logic [NUM_W-1:0]        rec_num,
  input logic [TS_W-1:0]         rec_time
);

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  a_r11_valid_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && irq_valid |-> $past(req));

  a_r2_quiet_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(req) && ($past(coarse_cause[COARSE_W-1:0]) == '0) |-> !irq_valid);

  a_r7_masked_never_wins: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && irq_valid |->
      (($past(sw_mask_prev | sw_mask_cur) & (32'h8000_0000 >> irq_num)) == '0));

  a_r10_stb_on_high_num: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && (int'(irq_num) >= REC_MIN) |-> rec_stb);

  a_r10_stb_consistent: assert property (@(posedge clk) disable iff (!rst_n)
    rec_stb |-> irq_valid && (rec_num == irq_num) && (int'(irq_num) >= REC_MIN));

  a_r10_time_latched: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && rec_stb |-> rec_time == $past(timestamp));

  a_r10_hold_record: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !rec_stb |-> $stable(rec_num) && $stable(rec_time));

endmodule

bind intr_resolver intr_resolver_chk #(.TS_W(TS_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req          (req),
  .coarse_cause (coarse_cause),
  .sw_mask_prev (sw_mask_prev),
  .sw_mask_cur  (sw_mask_cur),
  .timestamp    (timestamp),
  .irq_valid    (irq_valid),
  .irq_num      (irq_num),
  .rec_stb      (rec_stb),
  .rec_num      (rec_num),
  .rec_time     (rec_time)
);

// File: tb/test_intr_resolver.sv
`timescale 1ns/1ps
module test_intr_resolver;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               req;
  logic [16:0]        coarse_cause;
  logic [13:0]        hw_mask;
  logic [15:0]        mem_stat;
  logic [15:0]        dsp_stat;
  logic [31:0]        ai_ctrl;
  logic [2:0][31:0]   exi_stat;
  logic [31:0]        sw_mask_prev;
  logic [31:0]        sw_mask_cur;
  logic [31:0]        timestamp;
  logic               irq_valid;
  logic [4:0]         irq_num;
  logic               rec_stb;
  logic [4:0]         rec_num;
  logic [31:0]        rec_time;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  intr_resolver #(.TS_W(32)) i_intr_resolver (
    .clk (clk), .rst_n (rst_n), .req (req),
    .coarse_cause (coarse_cause), .hw_mask (hw_mask),
    .mem_stat (mem_stat), .dsp_stat (dsp_stat), .ai_ctrl (ai_ctrl),
    .exi_stat (exi_stat), .sw_mask_prev (sw_mask_prev),
    .sw_mask_cur (sw_mask_cur), .timestamp (timestamp),
    .irq_valid (irq_valid), .irq_num (irq_num), .rec_stb (rec_stb),
    .rec_num (rec_num), .rec_time (rec_time)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    coarse_cause = '0; hw_mask = 14'h3FFF; mem_stat = '0; dsp_stat = '0;
    ai_ctrl = '0; exi_stat = '0; sw_mask_prev = '0; sw_mask_cur = '0;
  endtask

  // drive req for one cycle, sample after the capturing edge
  task automatic fire(input logic [31:0] ts);
    @(negedge clk);
    timestamp = ts;
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    timestamp = 32'hFFFF_FFFF;
  endtask

  task automatic expect_irq(input string tag, input int num);
    check({tag, " valid"}, {31'd0, irq_valid}, 32'd1);
    check({tag, " num"}, {27'd0, irq_num}, num);
  endtask

  task automatic expect_none(input string tag);
    check({tag, " no valid"}, {31'd0, irq_valid}, 32'd0);
  endtask

  task automatic t_reset();
    check("R1 valid", {31'd0, irq_valid}, 0);
    check("R1 stb", {31'd0, rec_stb}, 0);
    check("R1 rec_num", {27'd0, rec_num}, 0);
    check("R1 rec_time", rec_time, 0);
  endtask

  task automatic t_gate();
    clear_in(); coarse_cause = 17'h10000; fire(1);
    expect_none("R2 state bit only");
    clear_in(); coarse_cause[3] = 1'b1; hw_mask = 14'h0004; fire(2);
    expect_none("R2 no overlap");
    clear_in(); coarse_cause[3] = 1'b1; coarse_cause[0] = 1'b1; hw_mask = 14'h0008; fire(3);
    expect_irq("R2 hw mask only gates", 23);
  endtask

  task automatic t_onetoone();
    clear_in(); coarse_cause[3] = 1'b1; coarse_cause[16] = 1'b1; fire(32'h1234);
    expect_irq("R6 SI", 20);
    check("R10 stb SI", {31'd0, rec_stb}, 1);
    check("R10 rec_num SI", {27'd0, rec_num}, 20);
    check("R10 rec_time SI", rec_time, 32'h1234);
    @(negedge clk);
    check("R11 pulse ends", {31'd0, irq_valid}, 0);
    clear_in(); coarse_cause[8] = 1'b1; fire(5); expect_irq("R6 VI", 24);
    clear_in(); coarse_cause[11] = 1'b1; fire(6); expect_irq("R6 CP", 17);
  endtask

  task automatic t_mem();
    clear_in(); coarse_cause[7] = 1'b1; mem_stat = 16'h0004; fire(32'h77);
    expect_irq("R3 MEM2", 2);
    check("R10 no stb below 5", {31'd0, rec_stb}, 0);
    check("R10 rec_time held", rec_time, 32'h0000_0006);
    mem_stat = 16'h0010; fire(8); expect_irq("R3 MADDR", 4);
    check("R10 rec_num held", {27'd0, rec_num}, 17);
    mem_stat = 16'h001F; fire(9); expect_irq("R9 MEM group lowest num", 0);
    clear_in(); coarse_cause[3] = 1'b1; mem_stat = 16'h001F; fire(10);
    expect_irq("R3 mem ignored when coarse clear", 20);
  endtask

  task automatic t_dsp_ai();
    clear_in(); coarse_cause[6] = 1'b1; dsp_stat = 16'h0020; fire(11);
    expect_irq("R4 DSP_ARAM", 6);
    dsp_stat = 16'h0008; fire(32'hABCD); expect_irq("R4 DSP_AI", 5);
    check("R10 stb at 5", {31'd0, rec_stb}, 1);
    check("R10 time at 5", rec_time, 32'hABCD);
    dsp_stat = 16'h0000; fire(12); expect_none("R4 DSP no status");
    clear_in(); coarse_cause[5] = 1'b1; dsp_stat = 16'h0008; fire(13);
    expect_none("R4 AI without audio bit");
    ai_ctrl = 32'h8; fire(14); expect_irq("R4 AI", 8);
  endtask

  task automatic t_exi();
    clear_in(); coarse_cause[4] = 1'b1; exi_stat[2] = 32'h800; fire(15);
    expect_none("R5 ch2 no EXT");
    exi_stat[2] = 32'h8; fire(16); expect_irq("R5 ch2 TC", 16);
    exi_stat[2] = 0; exi_stat[1] = 32'h800; fire(17); expect_irq("R5 ch1 EXT", 14);
    exi_stat[1] = 0; exi_stat[0] = 32'h2; fire(18); expect_irq("R5 ch0 EXI", 9);
    coarse_cause[4] = 1'b0; coarse_cause[2] = 1'b1; fire(19);
    expect_irq("R5 exi ignored when coarse clear", 21);
  endtask

  task automatic t_prio();
    clear_in(); coarse_cause[11] = 1'b1; coarse_cause[6] = 1'b1; dsp_stat = 16'h8; fire(20);
    expect_irq("R8 DSP_AI over CP", 5);
    dsp_stat = 16'h88; fire(21); expect_irq("R8 DSP_DSP over DSP_AI", 7);
    clear_in(); coarse_cause[0] = 1'b1; coarse_cause[13] = 1'b1; fire(22);
    expect_irq("R8 ERROR over HSP", 23);
    clear_in(); coarse_cause[8] = 1'b1; coarse_cause[1] = 1'b1; fire(23);
    expect_irq("R8 RSW over VI", 22);
    clear_in(); coarse_cause[13] = 1'b1; coarse_cause[3] = 1'b1; fire(24);
    expect_irq("R8 HSP over SI", 26);
    clear_in(); coarse_cause[7] = 1'b1; coarse_cause[12] = 1'b1; mem_stat = 16'h1; fire(25);
    expect_irq("R8 DEBUG over MEM", 25);
  endtask

  task automatic t_clz();
    clear_in(); coarse_cause[9] = 1'b1; coarse_cause[10] = 1'b1; fire(26);
    expect_irq("R9 PE group", 18);
    clear_in(); coarse_cause[3] = 1'b1; coarse_cause[2] = 1'b1; coarse_cause[4] = 1'b1;
    exi_stat[0] = 32'h800; fire(27); expect_irq("R9 mixed group", 11);
  endtask

  task automatic t_sw_mask();
    clear_in(); coarse_cause[3] = 1'b1; coarse_cause[2] = 1'b1; sw_mask_prev = 32'h0800; fire(28);
    expect_irq("R7 prev mask", 21);
    sw_mask_cur = 32'h0400; fire(29); expect_none("R7 both masked");
    sw_mask_prev = 0; fire(30); expect_irq("R7 cur mask", 20);
  endtask

  task automatic t_noreq();
    clear_in(); coarse_cause[0] = 1'b1;
    repeat (3) @(negedge clk);
    expect_none("R11 no req");
    check("R11 no stb", {31'd0, rec_stb}, 0);
  endtask

  initial begin
    req = 1'b0; timestamp = '0; clear_in();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_gate();
    t_onetoone();
    t_mem();
    t_dsp_ai();
    t_exi();
    t_prio();
    t_clz();
    t_sw_mask();
    t_noreq();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule